// File: doc/BRIEF.md
# Serial Receiver with Address-Frame Filtering

This block is an asynchronous serial receiver for a shared line where one sender talks to several listeners. Every character carries a frame-type bit. A 1 marks an address frame and a 0 marks a data frame. For 9-bit characters this bit is the ninth data bit. For 5- to 8-bit characters it is the first stop bit, and a second stop bit follows it on the line.

A listener that waits to be addressed turns the filter mode on. In filter mode, completed data frames are thrown away without any trace, and only address frames reach the receive buffer. The host reads each address and compares it with its own. When it has been selected, it turns the filter off so that the data frames that follow are delivered. When the exchange is over, it turns the filter back on.

The receiver oversamples the line. It counts one bit per 16 pulses of a baud tick input, decides each bit by a majority vote, and drops short glitches on the start bit. The received character is held in a single buffer with a receive-complete flag, a frame-error flag and an overrun flag. A read strobe clears all three flags.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, `rx_done_o`, `frame_err_o`, `overrun_o`, `type_o` and `data_o` are all zero.
- R2: A frame is a low start bit, then the data bits least-significant first, then the frame-type bit, then one final stop bit. Each bit lasts 16 `tick_i` pulses.
- R3: With `char_size_i` = 9, `data_o` carries the first eight data bits and `type_o` carries the ninth bit.
- R4: With `char_size_i` from 5 to 8, `data_o` holds the received bits in its low positions and zeros above them. `type_o` is the value of the first stop bit.
- R5: While `filter_en_i` is 1, a completed frame with type bit 0 leaves `rx_done_o`, `data_o`, `type_o`, `frame_err_o` and `overrun_o` unchanged.
- R6: While `filter_en_i` is 1, a completed frame with type bit 1 is delivered and sets `rx_done_o`.
- R7: While `filter_en_i` is 0, every completed frame is delivered, whatever its type bit.
- R8: A start bit that is high at its midpoint vote is treated as noise. The receiver returns to idle and delivers nothing.
- R9: A delivered frame whose final stop bit samples low sets `frame_err_o` together with `rx_done_o`. A discarded frame never sets it.
- R10: A frame delivered while `rx_done_o` is 1 (with no read in that cycle) sets `overrun_o` and is dropped. The buffer keeps the earlier character.
- R11: A clock cycle with `rd_i` high clears `rx_done_o`, `frame_err_o` and `overrun_o` at that same clock edge. The one exception is when a new frame is delivered in that cycle; the new frame is loaded.
- R12: Each bit value is the majority of the samples taken at tick counts 7, 8 and 9 of that bit. A single disturbed sample does not change the bit.
- R13: A `char_size_i` value below 5 acts as 5, and a value above 9 acts as 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oversampling tick, 16 per bit time |
| rxd_i | input | 1 | Serial line, idle high |
| char_size_i | input | 4 | Character size in bits, 5 to 9 |
| filter_en_i | input | 1 | Filter mode: discard data frames |
| rd_i | input | 1 | Read strobe, clears the status flags |
| data_o | output | 8 | Received character |
| type_o | output | 1 | Frame-type bit of the received character |
| rx_done_o | output | 1 | Receive-complete flag |
| frame_err_o | output | 1 | Final stop bit was low |
| overrun_o | output | 1 | A delivered frame was lost because the buffer was full |

## Verification
Frames are sent with both type values, first with the filter off and then with it on. This shows that the type bit alone decides between delivery and discard. Discarded frames are sent both while the buffer is empty and while it is full. These cases show that a dropped frame touches neither the buffer nor any flag, and that it cannot raise an overrun. Characters of 5, 7, 8 and 9 bits, plus sizes out of range, check the alignment and zero-filling of `data_o`. The same cases check that the type bit is taken from the right place on the line. One-sample line disturbances, short start pulses and low final stop bits separate the majority vote, the start-bit noise rejection and the frame-error path from the normal receive path.

// File: rtl/mp_uart_rx_pkg.sv
package mp_uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_TYPE,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/mp_rx_line_sync.sv
module mp_rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b1;
      else if (g == 0) chain_q[g] <= d_i;
      else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mp_rx_framer.sv
module mp_rx_framer
  import mp_uart_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8,
  parameter int SIZE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              frm_valid_o,
  output logic [DATA_W-1:0] frm_data_o,
  output logic              frm_type_o,
  output logic              frm_stop_ok_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam int MID   = OSR / 2;
  localparam logic [CNT_W-1:0] SMP_A = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] SMP_B = CNT_W'(MID);
  localparam logic [CNT_W-1:0] SMP_C = CNT_W'(MID + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(OSR - 1);
  localparam int MIN_SIZE = 5;

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q, nb_q, nb_req;
  logic [1:0]        votes_q;
  logic [DATA_W-1:0] shreg_q;
  logic              maj;

  // data-field width: clamp to [5, DATA_W]; 9-bit mode uses DATA_W data bits
  always_comb begin
    if (32'(size_i) < MIN_SIZE)       nb_req = IDX_W'(MIN_SIZE);
    else if (32'(size_i) >= DATA_W)   nb_req = IDX_W'(DATA_W);
    else                              nb_req = IDX_W'(size_i);
  end

  assign maj = (votes_q[0] & votes_q[1]) | (votes_q[0] & line_i) | (votes_q[1] & line_i);
  assign frm_data_o = shreg_q >> (IDX_W'(DATA_W) - nb_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      cnt_q         <= '0;
      idx_q         <= '0;
      nb_q          <= IDX_W'(DATA_W);
      votes_q       <= '0;
      shreg_q       <= '0;
      frm_valid_o   <= 1'b0;
      frm_type_o    <= 1'b0;
      frm_stop_ok_o <= 1'b0;
    end else begin
      frm_valid_o <= 1'b0;
      if (tick_i) begin
        if (state_q == ST_IDLE) begin
          if (!line_i) begin
            state_q <= ST_START;
            cnt_q   <= '0;
            nb_q    <= nb_req;
          end
        end else begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
          if (cnt_q == SMP_A) votes_q[0] <= line_i;
          if (cnt_q == SMP_B) votes_q[1] <= line_i;
          if (cnt_q == SMP_C) begin
            unique case (state_q)
              ST_START: if (maj) state_q <= ST_IDLE;
              ST_DATA:  shreg_q <= {maj, shreg_q[DATA_W-1:1]};
              ST_TYPE:  frm_type_o <= maj;
              ST_STOP: begin
                frm_valid_o   <= 1'b1;
                frm_stop_ok_o <= maj;
                state_q       <= ST_IDLE;
              end
              default: ;
            endcase
          end
          if (cnt_q == LAST) begin
            unique case (state_q)
              ST_START: begin
                state_q <= ST_DATA;
                idx_q   <= '0;
              end
              ST_DATA: begin
                if (idx_q == nb_q - 1'b1) state_q <= ST_TYPE;
                else idx_q <= idx_q + 1'b1;
              end
              ST_TYPE: state_q <= ST_STOP;
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/mp_rx_deliver.sv
module mp_rx_deliver #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              filter_en_i,
  input  logic              rd_i,
  input  logic              frm_valid_i,
  input  logic [DATA_W-1:0] frm_data_i,
  input  logic              frm_type_i,
  input  logic              frm_stop_ok_i,
  output logic [DATA_W-1:0] data_o,
  output logic              type_o,
  output logic              rx_done_o,
  output logic              frame_err_o,
  output logic              overrun_o
);
  logic accept;

  assign accept = frm_valid_i & (~filter_en_i | frm_type_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o      <= '0;
      type_o      <= 1'b0;
      rx_done_o   <= 1'b0;
      frame_err_o <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      if (rd_i) begin
        rx_done_o   <= 1'b0;
        frame_err_o <= 1'b0;
        overrun_o   <= 1'b0;
      end
      if (accept) begin
        if (rx_done_o && !rd_i) begin
          overrun_o <= 1'b1;
        end else begin
          data_o      <= frm_data_i;
          type_o      <= frm_type_i;
          rx_done_o   <= 1'b1;
          frame_err_o <= ~frm_stop_ok_i;
        end
      end
    end
  end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int SIZE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic [SIZE_W-1:0] char_size_i,
  input  logic              filter_en_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              type_o,
  output logic              rx_done_o,
  output logic              frame_err_o,
  output logic              overrun_o
);
  logic              line_s;
  logic              frm_valid, frm_type, frm_stop_ok;
  logic [DATA_W-1:0] frm_data;

  mp_rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (line_s)
  );

  mp_rx_framer #(.OSR(OSR), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_framer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .line_i       (line_s),
    .size_i       (char_size_i),
    .frm_valid_o  (frm_valid),
    .frm_data_o   (frm_data),
    .frm_type_o   (frm_type),
    .frm_stop_ok_o(frm_stop_ok)
  );

  mp_rx_deliver #(.DATA_W(DATA_W)) u_deliver (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .filter_en_i  (filter_en_i),
    .rd_i         (rd_i),
    .frm_valid_i  (frm_valid),
    .frm_data_i   (frm_data),
    .frm_type_i   (frm_type),
    .frm_stop_ok_i(frm_stop_ok),
    .data_o       (data_o),
    .type_o       (type_o),
    .rx_done_o    (rx_done_o),
    .frame_err_o  (frame_err_o),
    .overrun_o    (overrun_o)
  );
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              filter_en_i,
  input logic              rd_i,
  input logic              frm_valid,
  input logic              frm_type,
  input logic [DATA_W-1:0] data_o,
  input logic              rx_done_o,
  input logic              frame_err_o,
  input logic              overrun_o
);
  p_drop_keeps_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid && filter_en_i && !frm_type && !rx_done_o |=> !rx_done_o);

  p_drop_keeps_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid && filter_en_i && !frm_type |=> $stable(data_o));

  p_addr_delivered_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid && frm_type |=> rx_done_o);

  p_unfiltered_delivered_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid && !filter_en_i |=> rx_done_o);

  p_ferr_needs_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> rx_done_o);

  p_overrun_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid && (!filter_en_i || frm_type) && rx_done_o && !rd_i |=> overrun_o);

  p_full_holds_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o && !rd_i |=> $stable(data_o));

  p_read_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !(frm_valid && (!filter_en_i || frm_type)) |=> !rx_done_o && !overrun_o && !frame_err_o);
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mp_uart_rx_tb_top.sv
module mp_uart_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       rxd = 1'b1;
  logic [3:0] size = 4'd9;
  logic       filt = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] data;
  logic       typ, done, ferr, ovr;
  int         n_chk = 0, n_fail = 0;
  bit         finished = 1'b0;

  mp_uart_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd),
    .char_size_i(size), .filter_en_i(filt), .rd_i(rd),
    .data_o(data), .type_o(typ), .rx_done_o(done),
    .frame_err_o(ferr), .overrun_o(ovr)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // glitch_bit: bit index (0 = start) whose sample 8 is inverted; -1 for none
  task automatic send(input int sz, input logic [7:0] d, input logic t,
                      input logic stop, input int glitch_bit);
    int nb;
    logic [11:0] bits;
    nb = (sz < 5) ? 5 : (sz > 8) ? 8 : sz;
    bits = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < nb; i++) bits[1+i] = d[i];
    bits[nb+1] = t;
    bits[nb+2] = stop;
    size = 4'(sz);
    for (int b = 0; b < nb + 3; b++)
      for (int s = 0; s < 16; s++) begin
        @(negedge clk);
        rxd = bits[b] ^ ((b == glitch_bit) && (s == 8));
      end
    @(negedge clk);
    rxd = 1'b1;
    repeat (30) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset();
    check(done == 0 && ferr == 0 && ovr == 0 && typ == 0 && data == 0, "R1 reset",
          {data, typ, done, ferr, ovr}, 0);
  endtask

  task automatic t_nine_bit();
    filt = 0;
    send(9, 8'hA5, 1'b1, 1'b1, -1);
    check(done == 1, "R2 done after frame", done, 1);
    check(data == 8'hA5, "R3 data 9-bit", data, 8'hA5);
    check(typ == 1, "R3 ninth bit", typ, 1);
    do_read();
    check(done == 0 && ferr == 0 && ovr == 0, "R11 read clears", {done, ferr, ovr}, 0);
    send(9, 8'h3C, 1'b0, 1'b1, -1);
    check(data == 8'h3C && typ == 0 && done == 1, "R3 ninth bit zero", {data, typ}, {8'h3C, 1'b0});
    do_read();
  endtask

  task automatic t_short();
    send(5, 8'hFF, 1'b1, 1'b1, -1);
    check(data == 8'h1F, "R4 5-bit upper zero", data, 8'h1F);
    check(typ == 1, "R4 first stop as type", typ, 1);
    do_read();
    send(7, 8'hD5, 1'b0, 1'b1, -1);
    check(data == 8'h55 && typ == 0, "R4 7-bit", {data, typ}, {8'h55, 1'b0});
    do_read();
    send(8, 8'h81, 1'b1, 1'b1, -1);
    check(data == 8'h81 && typ == 1, "R4 8-bit", {data, typ}, {8'h81, 1'b1});
    do_read();
  endtask

  task automatic t_filter();
    filt = 1;
    send(9, 8'h11, 1'b0, 1'b1, -1);
    check(done == 0, "R5 data frame not flagged", done, 0);
    check(data == 8'h81 && typ == 1, "R5 buffer unchanged", {data, typ}, {8'h81, 1'b1});
    send(9, 8'h22, 1'b0, 1'b0, -1);
    check(done == 0 && ferr == 0, "R9 discarded bad stop no flag", {done, ferr}, 0);
    send(9, 8'h42, 1'b1, 1'b1, -1);
    check(done == 1 && data == 8'h42 && typ == 1, "R6 address delivered", {done, data}, {1'b1, 8'h42});
    send(9, 8'h33, 1'b0, 1'b1, -1);
    check(ovr == 0 && data == 8'h42, "R5 dropped frame no overrun", {ovr, data}, {1'b0, 8'h42});
    do_read();
  endtask

  task automatic t_filter_off();
    filt = 0;
    send(9, 8'h77, 1'b0, 1'b1, -1);
    check(done == 1 && data == 8'h77 && typ == 0, "R7 data delivered", {done, data}, {1'b1, 8'h77});
    do_read();
    send(6, 8'h2A, 1'b1, 1'b1, -1);
    check(done == 1 && data == 8'h2A && typ == 1, "R7 address delivered", {done, data}, {1'b1, 8'h2A});
    do_read();
  endtask

  task automatic t_glitch();
    @(negedge clk); rxd = 0;
    repeat (4) @(negedge clk);
    rxd = 1;
    repeat (60) @(negedge clk);
    check(done == 0, "R8 start glitch ignored", done, 0);
    send(9, 8'h5A, 1'b1, 1'b1, -1);
    check(done == 1 && data == 8'h5A, "R8 next frame ok", data, 8'h5A);
    do_read();
  endtask

  task automatic t_ferr();
    send(9, 8'h99, 1'b1, 1'b0, -1);
    check(done == 1 && ferr == 1 && data == 8'h99, "R9 frame error", {done, ferr}, 2'b11);
    do_read();
    check(ferr == 0, "R11 read clears ferr", ferr, 0);
    send(5, 8'h15, 1'b1, 1'b0, -1);
    check(ferr == 1 && data == 8'h15, "R9 short frame second stop low", {ferr, data}, {1'b1, 8'h15});
    do_read();
  endtask

  task automatic t_overrun();
    send(9, 8'hC3, 1'b1, 1'b1, -1);
    send(9, 8'h3C, 1'b1, 1'b1, -1);
    check(ovr == 1, "R10 overrun set", ovr, 1);
    check(data == 8'hC3 && done == 1, "R10 old data kept", data, 8'hC3);
    do_read();
    check(ovr == 0 && done == 0, "R11 read clears overrun", {ovr, done}, 0);
  endtask

  task automatic t_majority();
    send(9, 8'h00, 1'b0, 1'b1, 3);
    check(data == 8'h00 && done == 1, "R12 single sample glitch", data, 0);
    do_read();
    send(9, 8'hFF, 1'b1, 1'b1, 8);
    check(data == 8'hFF, "R12 glitch on high bit", data, 8'hFF);
    do_read();
  endtask

  task automatic t_clamp();
    send(15, 8'hE7, 1'b1, 1'b1, -1);
    check(data == 8'hE7 && typ == 1, "R13 size above 9", {data, typ}, {8'hE7, 1'b1});
    do_read();
    send(2, 8'h1B, 1'b0, 1'b1, -1);
    check(data == 8'h1B && typ == 0, "R13 size below 5", {data, typ}, {8'h1B, 1'b0});
    do_read();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_nine_bit();
    t_short();
    t_filter();
    t_filter_off();
    t_glitch();
    t_ferr();
    t_overrun();
    t_majority();
    t_clamp();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule